// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees a two-wire bus whose data line is held low by a target left halfway through a byte, usually because the controller was reset during a read. The sequencer drives the pull-down enables of both open-drain lines and reads both lines back. It can be started by an explicit recovery request. It also starts by itself when the transfer engine attempts a START while the clock line is high and the data line is low, which is the stuck-bus signature.

Once running, the sequencer claims the lines through an ownership output. It then delivers clock pulses one at a time and reads the data line during the low phase after each pulse. As soon as the data line reads high, it ends the orphaned transaction with a STOP. If the line stays low after the permitted number of pulses, it gives up. A one-cycle done strobe reports one of three outcomes: recovery was not needed, the bus was recovered, or recovery failed. Neither line is ever driven high. A line goes high only when every pull-down on it is released.

Top module: `bus_unjam`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `scl_pd_o`, `sda_pd_o`, `own_o` and `done_o` are all 0.
- R2: A `kick_i` pulse while `sda_in_i` reads high raises `done_o` in the next cycle with `status_o` = 2'b01 (not needed). It produces no clock activity and never asserts `own_o`.
- R3: A `start_req_i` pulse while `scl_in_i` is high and `sda_in_i` is low starts a recovery. A `start_req_i` pulse while `sda_in_i` is high is ignored: no done strobe follows and `own_o` stays 0.
- R4: No more than MAX_PULSES (default 9) clock pulses are produced. `sda_in_i` is read in the last cycle of the low phase that follows each pulse. Pulsing stops at the first such read that finds the line high, so the pulse count equals the number of pulses the target needs.
- R5: Each low phase holds `scl_pd_o` for `lo_len_i` cycles. The high phase is counted only while `scl_in_i` reads high, so the line is seen high for exactly `hi_len_i` cycles per pulse, even when a target stretches the low phase.
- R6: STOP order: SDA is pulled low while SCL is held low. SCL is then released and observed high for `hi_len_i` cycles. SDA is then released while SCL stays high. SDA never falls while SCL is high during a recovery.
- R7: If SDA still reads low in the low phase after pulse MAX_PULSES, both lines are released and `done_o` comes with `status_o` = 2'b11 (failed).
- R8: `done_o` lasts one cycle. A completed STOP reports `status_o` = 2'b10 (recovered), and `status_o` is never 2'b00 with `done_o`. `own_o` is 0 in the done cycle. Both pull-down enables are 0 whenever `own_o` is 0.
- R9: `kick_i` and `start_req_i` pulses that arrive during a recovery are ignored: exactly one done strobe results, with the outcome of the running recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick_i | input | 1 | Recovery request pulse |
| start_req_i | input | 1 | START attempt from the transfer engine |
| lo_len_i | input | CW | Clock low phase length in cycles (0 acts as 1) |
| hi_len_i | input | CW | Clock high phase length in cycles (0 acts as 1) |
| scl_in_i | input | 1 | Sampled clock line |
| sda_in_i | input | 1 | Sampled data line |
| scl_pd_o | output | 1 | Clock line pull-down enable |
| sda_pd_o | output | 1 | Data line pull-down enable |
| own_o | output | 1 | Sequencer owns the lines |
| done_o | output | 1 | One-cycle completion strobe |
| status_o | output | 2 | 01 not needed, 10 recovered, 11 failed |

## Verification
Two pairs of events can land in the same cycle. The first pair is an explicit recovery request and a START attempt on a stuck bus. The bench raises `kick_i` and `start_req_i` in one cycle and expects a single recovery with exactly one done strobe. The second pair is a target's clock stretch and the start of the sequencer's high phase. A target model holds SCL low for several cycles after each falling edge. The bench then judges each observed high run against `hi_len_i`, checks the pulse count, and checks that a STOP appears.

// File: rtl/bus_unjam.sv
module bus_unjam #(
  parameter int CW         = 8,
  parameter int MAX_PULSES = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick_i,
  input  logic          start_req_i,
  input  logic [CW-1:0] lo_len_i,
  input  logic [CW-1:0] hi_len_i,
  input  logic          scl_in_i,
  input  logic          sda_in_i,
  output logic          scl_pd_o,
  output logic          sda_pd_o,
  output logic          own_o,
  output logic          done_o,
  output logic [1:0]    status_o
);
  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam logic [1:0] ST_SKIP = 2'b01;
  localparam logic [1:0] ST_OK   = 2'b10;
  localparam logic [1:0] ST_FAIL = 2'b11;

  typedef enum logic [2:0] {IDLE, CLK_LO, CLK_HI, STP_LO, STP_HI} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] npulse;

  wire [CW:0] cnt_nx = {1'b0, cnt} + (CW+1)'(1);
  wire lo_end = cnt_nx >= {1'b0, lo_len_i};
  wire hi_end = cnt_nx >= {1'b0, hi_len_i};
  wire trig   = kick_i | (start_req_i & scl_in_i & ~sda_in_i);

  assign scl_pd_o = (st == CLK_LO) || (st == STP_LO);
  assign sda_pd_o = (st == STP_LO) || (st == STP_HI);
  assign own_o    = (st != IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      npulse   <= '0;
      done_o   <= 1'b0;
      status_o <= 2'b00;
    end else begin
      done_o <= 1'b0;
      case (st)
        IDLE: if (trig) begin
          if (sda_in_i) begin
            done_o   <= 1'b1;
            status_o <= ST_SKIP;
          end else begin
            st     <= CLK_LO;
            cnt    <= '0;
            npulse <= '0;
          end
        end
        CLK_LO: if (lo_end) begin
          cnt <= '0;
          if (npulse != '0 && sda_in_i)
            st <= STP_LO;
          else if (npulse == PW'(MAX_PULSES)) begin
            st       <= IDLE;
            done_o   <= 1'b1;
            status_o <= ST_FAIL;
          end else
            st <= CLK_HI;
        end else
          cnt <= cnt + CW'(1);
        CLK_HI: if (!scl_in_i)
          cnt <= '0;
        else if (hi_end) begin
          cnt    <= '0;
          npulse <= npulse + PW'(1);
          st     <= CLK_LO;
        end else
          cnt <= cnt + CW'(1);
        STP_LO: if (lo_end) begin
          cnt <= '0;
          st  <= STP_HI;
        end else
          cnt <= cnt + CW'(1);
        STP_HI: if (!scl_in_i)
          cnt <= '0;
        else if (hi_end) begin
          cnt      <= '0;
          st       <= IDLE;
          done_o   <= 1'b1;
          status_o <= ST_OK;
        end else
          cnt <= cnt + CW'(1);
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_unjam_chk.sv
module bus_unjam_chk #(
  parameter int MAX_PULSES = 9
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in_i,
  input logic       scl_pd_o,
  input logic       sda_pd_o,
  input logic       own_o,
  input logic       done_o,
  input logic [1:0] status_o
);
  logic       scl_pd_q;
  logic [7:0] rel_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pd_q <= 1'b0;
      rel_cnt  <= '0;
    end else begin
      scl_pd_q <= scl_pd_o;
      if (!own_o)
        rel_cnt <= '0;
      else if (scl_pd_q && !scl_pd_o)
        rel_cnt <= rel_cnt + 8'd1;
    end
  end

  p_pulse_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_cnt <= 8'(MAX_PULSES + 1));

  p_sda_pull_in_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pd_o) |-> scl_pd_o);

  p_stop_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pd_o) |-> (!scl_pd_o && scl_in_i));

  p_done_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (status_o != 2'b00 && !own_o));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_released_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !own_o |-> (!scl_pd_o && !sda_pd_o));
endmodule

bind bus_unjam bus_unjam_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in_i(scl_in_i), .scl_pd_o(scl_pd_o),
  .sda_pd_o(sda_pd_o), .own_o(own_o), .done_o(done_o), .status_o(status_o)
);

// File: tb/bus_unjam_bench.sv
`timescale 1ns/1ps
module bus_unjam_bench;
  localparam int CW = 8;
  localparam int MAXP = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kick = 1'b0, start_req = 1'b0;
  logic [CW-1:0] lo_len = 8'd2, hi_len = 8'd2;
  logic scl_pd, sda_pd, own, done;
  logic [1:0] status;

  // target model
  logic arm = 1'b0;
  int   k_cfg = 0, s_cfg = 0;
  int   need = 0, st_cnt = 0;
  logic t_sda_hold = 1'b0, scl_prev = 1'b1;
  wire  t_scl_hold = (st_cnt != 0);
  wire  scl_line = !(scl_pd | t_scl_hold);
  wire  sda_line = !(sda_pd | t_sda_hold);

  int checks = 0, errors = 0, cyc = 0;
  int rises = 0, stops = 0, fstarts = 0, dones = 0, owns = 0, bad_runs = 0, run = 0;
  logic active = 1'b0, m_scl_q = 1'b1, m_sda_q = 1'b1;

  always #10 clk = ~clk;

  bus_unjam #(.CW(CW), .MAX_PULSES(MAXP)) u_bus_unjam (
    .clk(clk), .rst_n(rst_n), .kick_i(kick), .start_req_i(start_req),
    .lo_len_i(lo_len), .hi_len_i(hi_len), .scl_in_i(scl_line), .sda_in_i(sda_line),
    .scl_pd_o(scl_pd), .sda_pd_o(sda_pd), .own_o(own), .done_o(done), .status_o(status)
  );

  always @(posedge clk) begin
    scl_prev <= scl_line;
    if (arm) begin
      need       <= k_cfg;
      t_sda_hold <= (k_cfg != 0);
      st_cnt     <= 0;
    end else begin
      if (scl_prev && !scl_line) begin
        st_cnt <= s_cfg;
        if (need == 0) t_sda_hold <= 1'b0;
      end else if (st_cnt > 0)
        st_cnt <= st_cnt - 1;
      if (!scl_prev && scl_line && need > 0) need <= need - 1;
    end
  end

  always @(negedge clk) begin
    m_scl_q <= scl_line;
    m_sda_q <= sda_line;
    if (done) dones <= dones + 1;
    if (own) owns <= owns + 1;
    if (active && !m_scl_q && scl_line) rises <= rises + 1;
    if (active && m_scl_q && scl_line && !m_sda_q && sda_line) stops <= stops + 1;
    if (active && m_scl_q && scl_line && m_sda_q && !sda_line) fstarts <= fstarts + 1;
    if (!active) run <= 0;
    else if (own && scl_line) run <= run + 1;
    else if (!scl_line) begin
      if (run != 0 && run != int'(hi_len)) bad_runs <= bad_runs + 1;
      run <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // {K[4], stretch[4], lo[4], hi[4], mode[2] (0 kick,1 start,2 both), status[2]}
  localparam logic [19:0] VECS [0:7] = '{
    {4'd1,  4'd0, 4'd2, 4'd2, 2'd0, 2'b10},
    {4'd3,  4'd0, 4'd3, 4'd1, 2'd1, 2'b10},
    {4'd9,  4'd0, 4'd2, 4'd3, 2'd0, 2'b10},
    {4'd10, 4'd0, 4'd2, 4'd2, 2'd0, 2'b11},
    {4'd4,  4'd7, 4'd2, 4'd2, 2'd1, 2'b10},
    {4'd2,  4'd0, 4'd4, 4'd5, 2'd2, 2'b10},
    {4'd0,  4'd0, 4'd2, 4'd2, 2'd0, 2'b01},
    {4'd15, 4'd3, 4'd6, 4'd1, 2'd1, 2'b11}
  };

  task automatic arm_target(input int k, input int s);
    @(negedge clk);
    k_cfg = k; s_cfg = s; arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_done(output logic [1:0] st, input bit busy_kick);
    int n = 0;
    st = 2'b00;
    while (!done && n < 5000) begin
      @(negedge clk);
      kick = 1'b0; start_req = 1'b0;
      n++;
      if (busy_kick && n == 6) begin kick = 1'b1; start_req = 1'b1; end
    end
    st = status;
    @(negedge clk);
    kick = 1'b0; start_req = 1'b0;
    chk(done == 1'b0, "R8 done one cycle", done, 0);
    active = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [1:0] st;
    int r0, d0, s0, f0, b0, o0;
    repeat (3) @(negedge clk);
    chk(!scl_pd && !sda_pd && !own && !done, "R1 reset outputs",
        {scl_pd, sda_pd, own, done}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_pd && !sda_pd && !own && !done, "R1 after reset",
        {scl_pd, sda_pd, own, done}, 0);

    // table walk
    for (int i = 0; i < 8; i++) begin
      int k, exp_r;
      logic [1:0] es, md;
      k  = int'(VECS[i][19:16]);
      md = VECS[i][3:2];
      es = VECS[i][1:0];
      arm_target(k, int'(VECS[i][15:12]));
      lo_len = CW'(VECS[i][11:8]);
      hi_len = CW'(VECS[i][7:4]);
      r0 = rises; d0 = dones; s0 = stops; f0 = fstarts; b0 = bad_runs; o0 = owns;
      active = 1'b1;
      kick = (md != 2'd1);
      start_req = (md != 2'd0);
      wait_done(st, 1'b0);
      exp_r = (es == 2'b10) ? k + 1 : (es == 2'b11) ? MAXP + 1 : 0;
      chk(st == es, "R8 status (R2/R7)", st, es);
      chk(rises - r0 == exp_r, "R4 pulse count", rises - r0, exp_r);
      chk(dones - d0 == 1, "R8 single done", dones - d0, 1);
      chk(bad_runs == b0, "R5 high phase length", bad_runs - b0, 0);
      chk(stops - s0 == ((es == 2'b10) ? 1 : 0), "R6 stop seen", stops - s0, (es == 2'b10) ? 1 : 0);
      chk(fstarts == f0, "R6 no false start", fstarts - f0, 0);
      chk(!scl_pd && !sda_pd && !own, "R8 released", {scl_pd, sda_pd, own}, 0);
      if (es == 2'b01) chk(owns == o0, "R2 no ownership", owns - o0, 0);
      if (es == 2'b11) chk(sda_line == 1'b0, "R7 still stuck", sda_line, 0);
      if (es == 2'b10) chk(sda_line == 1'b1, "R6 bus idle", sda_line, 1);
    end

    // R3: START attempt on a healthy bus is ignored
    arm_target(0, 0);
    d0 = dones; o0 = owns;
    start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    repeat (20) @(negedge clk);
    chk(dones == d0, "R3 ignored start done", dones - d0, 0);
    chk(owns == o0, "R3 ignored start own", owns - o0, 0);

    // R9: requests during a recovery are ignored
    arm_target(3, 0);
    lo_len = 8'd3; hi_len = 8'd2;
    r0 = rises; d0 = dones;
    active = 1'b1;
    kick = 1'b1;
    wait_done(st, 1'b1);
    chk(st == 2'b10, "R9 status busy kick", st, 2'b10);
    chk(dones - d0 == 1, "R9 one done", dones - d0, 1);
    chk(rises - r0 == 4, "R9 pulse count", rises - r0, 4);

    finish_run();
  end
endmodule